// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This block holds the interrupt registers of an SPI master. It keeps a 7-bit status word made of two kinds of bits: sticky event latches (mode fault and the TX low-watermark crossing) that software acknowledges by writing ones, and live level flags (TX FIFO full and RX FIFO not empty) that follow the FIFO state. A 7-bit mask decides which status bits may raise the single interrupt line.

Software never writes the mask directly. One write port carries a register select and a data word. A write to the enable register sets every mask bit where the data has a one. A write to the disable register clears every such bit. A write to the status register acknowledges latched events. Because the ack is write-one-to-clear, the status value just read can be written straight back to retire exactly the events that were seen. The FIFO logic supplies the TX fill level, the programmed watermark, the RX empty flag and a one-cycle mode-fault pulse. The unit returns the status and mask words for readback and drives a registered interrupt request.

Top module: `spi_irq_unit`

## Requirements
- R1: While reset is held, the status word, the mask word and the interrupt line are all zero.
- R2: A write with wrSel = 1 (enable) sets each mask bit whose data bit is 1 on the next cycle. Mask bits whose data bit is 0 keep their value.
- R3: A write with wrSel = 2 (disable) clears each mask bit whose data bit is 1 on the next cycle. The mask is unchanged in any cycle with no enable or disable write, including a write with wrSel = 3.
- R4: A modeFault pulse sets status bit 1 on the next cycle. The bit stays set until a write with wrSel = 0 (status) carries a 1 in bit 1.
- R5: Status bit 2 is set on the cycle after txLevel goes from at-or-above txWatermark to below it (the edge detector starts as "not below" after reset). It stays set until acknowledged with a 1 in bit 2 of a status write. A level that stays below the watermark does not set it again.
- R6: Status bit 3 shows, one cycle late, whether txLevel is at least FIFO_DEPTH. A status write cannot clear it while that condition holds.
- R7: Status bit 4 shows, one cycle late, the inverse of rxEmpty. A status write cannot clear it while the RX FIFO holds data.
- R8: Status bits 0, 5 and 6 always read as zero.
- R9: When an event arrives in the same cycle as an acknowledge of its bit, the event wins and the bit stays set.
- R10: irq is high in a cycle exactly when the bitwise AND of status and mask was nonzero in the previous cycle.
- R11: Writing a status value back acknowledges only the latched bits that are 1 in the data. Other latched bits remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 status ack, 1 mask enable, 2 mask disable, 3 none |
| wrData | input | 7 | Write data, one bit per event |
| txLevel | input | LVL_W | Current TX FIFO fill level |
| txWatermark | input | LVL_W | TX low-watermark threshold |
| rxEmpty | input | 1 | RX FIFO empty flag |
| modeFault | input | 1 | One-cycle mode-fault event pulse |
| statusOut | output | 7 | Status word readback |
| maskOut | output | 7 | Mask word readback |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check how the mask responds to enable, disable and no-op writes, the one-cycle lag of the live full and not-empty flags, the mode-fault latch, the zero reserved bits and the one-cycle relation between irq and the masked status. Some behaviour spans several cycles and depends on history, and only the bench scenarios, compared against the reference model, can show it. This covers watermark edge detection (including a level that stays low), partial acknowledge by write-back, an event colliding with its own acknowledge, and acknowledge attempts on live flags.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int EVW       = 7;
  localparam int FAULT_BIT = 1;
  localparam int WMARK_BIT = 2;
  localparam int FULL_BIT  = 3;
  localparam int RXNE_BIT  = 4;

  localparam logic [1:0] SEL_ACK = 2'd0;
  localparam logic [1:0] SEL_ENA = 2'd1;
  localparam logic [1:0] SEL_DIS = 2'd2;

  typedef struct packed {
    logic [EVW-1:0] maskSet;
    logic [EVW-1:0] maskClr;
    logic [EVW-1:0] ack;
    logic           faultEv;
    logic           wmarkEv;
  } irqStrobes_t;
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [EVW-1:0]   wrData,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] txWatermark,
  input  logic             modeFault,
  output irqStrobes_t      strb
);
  logic belowNow;
  logic belowPrev;

  assign belowNow = (txLevel < txWatermark);

  // edge detector for the low-watermark crossing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) belowPrev <= 1'b0;
    else       belowPrev <= belowNow;
  end

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (wrSel)
        SEL_ACK: strb.ack     = wrData;
        SEL_ENA: strb.maskSet = wrData;
        SEL_DIS: strb.maskClr = wrData;
        default: ;
      endcase
    end
    strb.faultEv = modeFault;
    strb.wmarkEv = belowNow && !belowPrev;
  end
endmodule

// File: rtl/spi_irq_dp.sv
module spi_irq_dp
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobes_t      strb,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             rxEmpty,
  output logic [EVW-1:0]   statusOut,
  output logic [EVW-1:0]   maskOut,
  output logic             irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic           faultLat, wmarkLat, fullLvl, rxneLvl;
  logic [EVW-1:0] maskReg;
  logic           irqReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultLat <= 1'b0;
      wmarkLat <= 1'b0;
      fullLvl  <= 1'b0;
      rxneLvl  <= 1'b0;
      maskReg  <= '0;
      irqReg   <= 1'b0;
    end else begin
      // a new event takes priority over a same-cycle acknowledge
      faultLat <= strb.faultEv | (faultLat & ~strb.ack[FAULT_BIT]);
      wmarkLat <= strb.wmarkEv | (wmarkLat & ~strb.ack[WMARK_BIT]);
      fullLvl  <= (txLevel >= FULL_LVL);
      rxneLvl  <= !rxEmpty;
      maskReg  <= (maskReg | strb.maskSet) & ~strb.maskClr;
      irqReg   <= |(statusOut & maskReg);
    end
  end

  for (genvar i = 0; i < EVW; i++) begin : g_stat
    if (i == FAULT_BIT) begin : g_f
      assign statusOut[i] = faultLat;
    end else if (i == WMARK_BIT) begin : g_w
      assign statusOut[i] = wmarkLat;
    end else if (i == FULL_BIT) begin : g_t
      assign statusOut[i] = fullLvl;
    end else if (i == RXNE_BIT) begin : g_r
      assign statusOut[i] = rxneLvl;
    end else begin : g_z
      assign statusOut[i] = 1'b0;
    end
  end

  assign maskOut = maskReg;
  assign irq     = irqReg;
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [6:0]       wrData,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] txWatermark,
  input  logic             rxEmpty,
  input  logic             modeFault,
  output logic [6:0]       statusOut,
  output logic [6:0]       maskOut,
  output logic             irq
);
  irqStrobes_t strb;

  spi_irq_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .txLevel(txLevel), .txWatermark(txWatermark), .modeFault(modeFault),
    .strb(strb)
  );

  spi_irq_dp #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txLevel(txLevel),
    .rxEmpty(rxEmpty), .statusOut(statusOut), .maskOut(maskOut), .irq(irq)
  );
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk #(
  parameter int FIFO_DEPTH = 128,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrSel,
  input logic [6:0]       wrData,
  input logic [LVL_W-1:0] txLevel,
  input logic             rxEmpty,
  input logic             modeFault,
  input logic [6:0]       statusOut,
  input logic [6:0]       maskOut,
  input logic             irq
);
  // armed is high only once the previous edge also saw reset released
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |-> (statusOut == 7'd0 && maskOut == 7'd0 && !irq));

  assert_enable_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd1) |=> ((maskOut & $past(wrData)) == $past(wrData)));

  assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd2) |=> ((maskOut & $past(wrData)) == 7'd0));

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrSel == 2'd1 || wrSel == 2'd2)) |=> $stable(maskOut));

  assert_fault_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |=> statusOut[1]);

  assert_full_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (statusOut[3] == ($past(txLevel) >= LVL_W'(FIFO_DEPTH))));

  assert_rx_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (statusOut[4] == !$past(rxEmpty)));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[0] == 1'b0 && statusOut[6:5] == 2'b00));

  assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (irq == ($past(statusOut & maskOut) != 7'd0)));
endmodule

bind spi_irq_unit spi_irq_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .txLevel(txLevel), .rxEmpty(rxEmpty), .modeFault(modeFault),
  .statusOut(statusOut), .maskOut(maskOut), .irq(irq)
);

// File: tb/spi_irq_unit_tb.sv
module spi_irq_unit_tb;
  localparam int DEPTH = 128;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrSel = 2'd3;
  logic [6:0]    wrData = '0;
  logic [LW-1:0] txLevel = LW'(10);
  logic [LW-1:0] txWatermark = LW'(4);
  logic          rxEmpty = 1'b1;
  logic          modeFault = 1'b0;
  logic [6:0]    statusOut, maskOut;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_irq_unit #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .txLevel(txLevel), .txWatermark(txWatermark), .rxEmpty(rxEmpty),
    .modeFault(modeFault), .statusOut(statusOut), .maskOut(maskOut), .irq(irq)
  );

  // behavioural reference model
  bit mFault = 0, mWm = 0, mFull = 0, mRxne = 0, mBelowOld = 0, mIrq = 0;
  bit [6:0] mMask = 0;

  function automatic bit [6:0] modelStatus();
    bit [6:0] s = 0;
    s[1] = mFault; s[2] = mWm; s[3] = mFull; s[4] = mRxne;
    return s;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFault = 0; mWm = 0; mFull = 0; mRxne = 0; mBelowOld = 0; mIrq = 0; mMask = 0;
    end else begin
      bit below;
      bit [6:0] ackV;
      below = (int'(txLevel) < int'(txWatermark));
      ackV  = (wrEn && wrSel == 2'd0) ? wrData : 7'd0;
      mIrq  = ((modelStatus() & mMask) != 0);
      if (modeFault) mFault = 1; else if (ackV[1]) mFault = 0;
      if (below && !mBelowOld) mWm = 1; else if (ackV[2]) mWm = 0;
      mBelowOld = below;
      mFull = (int'(txLevel) >= DEPTH);
      mRxne = !rxEmpty;
      if (wrEn && wrSel == 2'd1) mMask = mMask | wrData;
      if (wrEn && wrSel == 2'd2) mMask = mMask & ~wrData;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) if (!done) begin
    bit [6:0] es;
    es = modelStatus();
    if (!rstN) check("R1 reset state", {statusOut, maskOut, irq}, 15'd0);
    check("R4 fault bit",        statusOut[1], es[1]);
    check("R5 R9 R11 wmark bit", statusOut[2], es[2]);
    check("R6 full bit",         statusOut[3], es[3]);
    check("R7 rx bit",           statusOut[4], es[4]);
    check("R8 reserved bits",    {statusOut[6:5], statusOut[0]}, 0);
    check("R2 R3 mask",          maskOut, mMask);
    check("R10 irq",             irq, mIrq);
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [6:0] d);
    wrEn = 1; wrSel = sel; wrData = d;
    cyc();
    wrEn = 0; wrSel = 2'd3; wrData = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    cyc(3);
    rstN = 1;
    cyc(2);
    // R2: enable fault, watermark and rx bits, then more
    wr(2'd1, 7'h16);
    cyc(2);
    // R7: rx data arrives, ack attempt has no lasting effect
    rxEmpty = 0; cyc(2);
    wr(2'd0, 7'h10); cyc(2);
    rxEmpty = 1; cyc(2);
    // R5: level crosses below watermark, stays low, then rises
    txLevel = LW'(3); cyc(3);
    txLevel = LW'(2); cyc(2);
    wr(2'd0, 7'h04); cyc(2);
    txLevel = LW'(8); cyc(2);
    // R4 and R11: both latches set, ack only fault
    modeFault = 1; txLevel = LW'(1); cyc();
    modeFault = 0; cyc(2);
    wr(2'd0, 7'h02); cyc(2);
    wr(2'd0, 7'h06); cyc(2);
    // R9: fault pulse collides with its ack
    modeFault = 1; wrEn = 1; wrSel = 2'd0; wrData = 7'h7F; cyc();
    modeFault = 0; wrEn = 0; wrSel = 2'd3; wrData = 0; cyc(2);
    // R6: full FIFO, enable its bit, ack cannot clear
    txLevel = LW'(DEPTH); cyc(2);
    wr(2'd1, 7'h08); wr(2'd0, 7'h7F); cyc(2);
    txLevel = LW'(DEPTH - 1); cyc(2);
    // R3: disable some, no-op select 3 leaves mask
    wr(2'd2, 7'h06); wr(2'd3, 7'h7F); wr(2'd2, 7'h7F); cyc(2);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      wrEn        = ($urandom % 4) == 0;
      wrSel       = 2'($urandom);
      wrData      = 7'($urandom);
      txLevel     = LW'($urandom % (DEPTH + 1));
      txWatermark = LW'($urandom % 16);
      rxEmpty     = ($urandom % 3) != 0;
      modeFault   = ($urandom % 8) == 0;
      cyc();
    end
    wrEn = 0; modeFault = 0; cyc(3);
    finishRun();
  end
endmodule